// File: doc/BRIEF.md
# Amplifier Control I2C Register Slave

This block is the two-wire serial control port of a four-channel amplifier diagnostic controller. A host writes two instruction bytes that set the amplifier's operating controls: diagnostic enable, offset check enable, low-gain select for the front and rear pairs, unmute for the front and rear pairs, clip threshold select, amplifier run (standby off), line-driver diagnostic thresholds and current-detect enable. A host read returns four status bytes, one per output channel, packed from the outputs of the diagnostic engines.

SCL and SDA are oversampled by the system clock. The block detects start and stop conditions, shifts bits in and out MSB first, and acknowledges its own address. It commits an instruction byte only after that byte's acknowledge clock has ended. At the address phase of a read it freezes a copy of all status inputs, so every byte in one read comes from the same instant. When the acknowledge clock of the fourth status byte ends, it sends a single-cycle rearm pulse that restarts every diagnostic cycle. The data just read therefore always describes the cycle that came before the read.

The pad is modelled as open drain. The block only pulls SDA low (`sda_oe_o` high) or releases it. It never stretches the clock.

Top module: `amp_ctl_i2c_slave`

## Requirements
- R1: After reset every control output is 0 (standby, both pairs muted, high gain, diagnostics off), SDA is released and no rearm pulse is issued.
- R2: The 7-bit device address is 1101100. Address byte 0xD8 starts a write and 0xD9 starts a read, and both are acknowledged. Any other address byte is not acknowledged, and the bytes that follow it have no effect until the next start.
- R3: An instruction byte cut short by a stop or a repeated start before its acknowledge clock has ended leaves the controls unchanged. A byte that has been acknowledged takes effect even if the transfer then ends.
- R4: In the first write byte, bit 6 is diagnostic enable, bit 5 is offset enable, bit 4 is front low gain, bit 3 is rear low gain, bit 2 is front unmute, bit 1 is rear unmute and bit 0 is clip threshold select. Bit 7 is ignored.
- R5: In the second write byte, bit 4 is amplifier run, bit 3 is line-driver diagnostics and bit 2 is current-detect enable. Bits 7, 6, 5, 1 and 0 are ignored.
- R6: A write acknowledges exactly two instruction bytes. A third byte is not acknowledged and changes nothing.
- R7: A read returns four bytes in channel order 0 to 3, MSB first. Bits 5..0 of byte n are `chan_status_i[6n+5:6n]`, whose fields are: bit 5 open tweeter, bit 4 permanent result, bit 3 short load, bit 2 open load or offset, bit 1 short to supply, bit 0 short to ground.
- R8: Bits 7/6 of byte 0 are the thermal warning and cycle-done inputs. Bits 7/6 of byte 1 are the offset-active and current-sensor-active inputs. Bits 7/6 of byte 2 echo the amplifier run and diagnostic enable controls. Bits 7/6 of byte 3 read 0.
- R9: All bytes of one read come from a copy of the status inputs and controls taken at the read address. Later input changes show only in the next read.
- R10: `rearm_o` pulses high for exactly one clock after the acknowledge clock of the fourth read byte, once per read. A read that ends before the fourth byte issues no pulse.
- R11: If the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next start.
- R12: The block changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| chan_status_i | input | NCH*6 | Per-channel fault fields, channel n at bits 6n+5..6n |
| thermal_warn_i | input | 1 | Thermal warning flag |
| cycle_done_i | input | 1 | Diagnostic cycle terminated flag |
| offset_active_i | input | 1 | Offset check running flag |
| cursens_active_i | input | 1 | Current sensor running flag |
| diag_en_o | output | 1 | Diagnostic enable |
| offset_en_o | output | 1 | Offset check enable |
| front_gain_lo_o | output | 1 | Front pair low gain |
| rear_gain_lo_o | output | 1 | Rear pair low gain |
| front_unmute_o | output | 1 | Front pair unmuted |
| rear_unmute_o | output | 1 | Rear pair unmuted |
| clip_sel_o | output | 1 | Clip detector threshold select |
| amp_run_o | output | 1 | Amplifier out of standby |
| line_drv_o | output | 1 | Line-driver diagnostic thresholds |
| cur_det_en_o | output | 1 | Current-detect diagnostic enable |
| rearm_o | output | 1 | One-cycle pulse restarting all diagnostic cycles |

## Verification
A wrong bit counter or phase state shows within one byte time: the acknowledge appears in the wrong SCL period or is missing, and the data returned to the host is shifted. A snapshot that is taken at the wrong time or refreshed during the read shows as a status byte that follows a live input change made in the middle of the transfer. A bad commit point shows in the control outputs as soon as a truncated byte ends. A wrong rearm condition shows as a pulse count that differs from the number of completed reads, visible right after the fourth acknowledge clock.

// File: rtl/amp_ctl_pkg.sv
package amp_ctl_pkg;

   localparam int unsigned CH_BITS = 6;
   localparam int unsigned BYTE_W  = 8;

   typedef enum logic [3:0] {
      LK_IDLE,
      LK_ADDR,
      LK_ACK_ADDR,
      LK_WR,
      LK_ACK_WR,
      LK_RD_LOAD,
      LK_RD,
      LK_RD_ACK,
      LK_SKIP
   } link_state_t;

endpackage

// File: rtl/amp_ctl_i2c_sync.sv
module amp_ctl_i2c_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          FILTER = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_hi,
   output logic sda_hi,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   if (STAGES < 2) begin : g_bad_stages
      $error("amp_ctl_i2c_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic scl_f, sda_f;
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      end
   end

   if (FILTER) begin : g_filter
      // two-of-three vote over consecutive synchronised samples
      logic [1:0] scl_h, sda_h;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_h <= '1;
            sda_h <= '1;
         end else begin
            scl_h <= {scl_h[0], scl_sh[STAGES-1]};
            sda_h <= {sda_h[0], sda_sh[STAGES-1]};
         end
      end
      assign scl_f = (scl_sh[STAGES-1] & scl_h[0]) | (scl_sh[STAGES-1] & scl_h[1]) | (scl_h[0] & scl_h[1]);
      assign sda_f = (sda_sh[STAGES-1] & sda_h[0]) | (sda_sh[STAGES-1] & sda_h[1]) | (sda_h[0] & sda_h[1]);
   end else begin : g_direct
      assign scl_f = scl_sh[STAGES-1];
      assign sda_f = sda_sh[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_hi <= 1'b1;
         sda_hi <= 1'b1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_hi <= scl_f;
         sda_hi <= sda_f;
         scl_d  <= scl_hi;
         sda_d  <= sda_hi;
      end
   end

   assign scl_rise = scl_hi & ~scl_d;
   assign scl_fall = ~scl_hi & scl_d;
   assign start_ev = scl_hi & scl_d & sda_d & ~sda_hi;
   assign stop_ev  = scl_hi & scl_d & ~sda_d & sda_hi;

endmodule

// File: rtl/amp_ctl_i2c_link.sv
module amp_ctl_i2c_link
   import amp_ctl_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h6C,
   parameter int unsigned WR_BYTES = 2,
   parameter int unsigned RD_BYTES = 4,
   localparam int unsigned IDX_W   = $clog2(RD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_hi,
   input  logic              sda_hi,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [BYTE_W-2:0] wr_data,
   output logic              snap_stb,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              done_stb
);

   if (WR_BYTES >= RD_BYTES || WR_BYTES < 1) begin : g_bad_wr
      $error("amp_ctl_i2c_link: WR_BYTES must be in 1..RD_BYTES-1");
   end
   if ((1 << IDX_W) != RD_BYTES) begin : g_bad_rd
      $error("amp_ctl_i2c_link: RD_BYTES must be a power of two");
   end

   link_state_t       st;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic              rw;
   logic              mack;
   logic [IDX_W-1:0]  idx;

   assign rd_idx = idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= LK_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         rw       <= 1'b0;
         mack     <= 1'b0;
         idx      <= '0;
         sda_oe   <= 1'b0;
         wr_stb   <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
         snap_stb <= 1'b0;
         done_stb <= 1'b0;
      end else begin
         wr_stb   <= 1'b0;
         snap_stb <= 1'b0;
         done_stb <= 1'b0;
         if (stop_ev) begin
            st     <= LK_IDLE;
            sda_oe <= 1'b0;
         end else if (start_ev) begin
            st     <= LK_ADDR;
            bitcnt <= '0;
            idx    <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               LK_ADDR, LK_WR: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_hi};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     if (st == LK_ADDR) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           rw     <= shreg[0];
                           sda_oe <= 1'b1;
                           st     <= LK_ACK_ADDR;
                        end else begin
                           st <= LK_SKIP;
                        end
                     end else if (idx < IDX_W'(WR_BYTES)) begin
                        sda_oe <= 1'b1;
                        st     <= LK_ACK_WR;
                     end else begin
                        st <= LK_SKIP;
                     end
                  end
               end
               LK_ACK_ADDR: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     if (rw) begin
                        snap_stb <= 1'b1;
                        st       <= LK_RD_LOAD;
                     end else begin
                        st <= LK_WR;
                     end
                  end
               end
               LK_ACK_WR: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     wr_stb  <= 1'b1;
                     wr_idx  <= idx;
                     wr_data <= shreg[BYTE_W-2:0];
                     idx     <= idx + 1'b1;
                     st      <= LK_WR;
                  end
               end
               LK_RD_LOAD: begin
                  sda_oe <= ~rd_byte[BYTE_W-1];
                  bitcnt <= '0;
                  st     <= LK_RD;
               end
               LK_RD: begin
                  if (scl_fall) begin
                     if (bitcnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        st     <= LK_RD_ACK;
                     end else begin
                        bitcnt <= bitcnt + 4'd1;
                        sda_oe <= ~rd_byte[3'd6 - bitcnt[2:0]];
                     end
                  end
               end
               LK_RD_ACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_hi;
                  end else if (scl_fall) begin
                     if (idx == IDX_W'(RD_BYTES - 1)) begin
                        done_stb <= 1'b1;
                        st       <= LK_SKIP;
                     end else if (mack) begin
                        idx <= idx + 1'b1;
                        st  <= LK_RD_LOAD;
                     end else begin
                        st <= LK_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R11: nothing is driven once the link is idle or ignoring the bus
   p_release_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_IDLE || st == LK_SKIP) |-> !sda_oe);

   // R12: the SDA drive is steady across a high SCL phase
   p_sda_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_hi && $past(scl_hi) && !$past(stop_ev) && !$past(start_ev)) |-> $stable(sda_oe));

endmodule

// File: rtl/amp_ctl_regs.sv
module amp_ctl_regs
   import amp_ctl_pkg::*;
#(
   parameter int unsigned NCH  = 4,
   localparam int unsigned IDX_W = $clog2(NCH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_stb,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [BYTE_W-2:0]      wr_data,
   input  logic                   snap_stb,
   input  logic [IDX_W-1:0]       rd_idx,
   input  logic [NCH*CH_BITS-1:0] chan_status,
   input  logic                   thermal_warn,
   input  logic                   cycle_done,
   input  logic                   offset_active,
   input  logic                   cursens_active,
   output logic [BYTE_W-1:0]      rd_byte,
   output logic                   diag_en,
   output logic                   offset_en,
   output logic                   front_gain_lo,
   output logic                   rear_gain_lo,
   output logic                   front_unmute,
   output logic                   rear_unmute,
   output logic                   clip_sel,
   output logic                   amp_run,
   output logic                   line_drv,
   output logic                   cur_det_en
);

   if (NCH != 4) begin : g_bad_nch
      $error("amp_ctl_regs: status byte layout is defined for four channels");
   end

   logic [6:0] ctl_a;
   logic [2:0] ctl_b;
   logic [BYTE_W-1:0] live_b [NCH];
   logic [BYTE_W-1:0] snap_b [NCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_a <= '0;
         ctl_b <= '0;
      end else if (wr_stb) begin
         if (wr_idx == '0) ctl_a <= wr_data[6:0];
         else if (wr_idx == IDX_W'(1)) ctl_b <= wr_data[4:2];
      end
   end

   assign diag_en       = ctl_a[6];
   assign offset_en     = ctl_a[5];
   assign front_gain_lo = ctl_a[4];
   assign rear_gain_lo  = ctl_a[3];
   assign front_unmute  = ctl_a[2];
   assign rear_unmute   = ctl_a[1];
   assign clip_sel      = ctl_a[0];
   assign amp_run       = ctl_b[2];
   assign line_drv      = ctl_b[1];
   assign cur_det_en    = ctl_b[0];

   for (genvar gi = 0; gi < NCH; gi++) begin : g_pack
      logic [1:0] hi_bits;
      if (gi == 0) begin : g_b0
         assign hi_bits = {thermal_warn, cycle_done};
      end else if (gi == 1) begin : g_b1
         assign hi_bits = {offset_active, cursens_active};
      end else if (gi == 2) begin : g_b2
         assign hi_bits = {amp_run, diag_en};
      end else begin : g_bx
         assign hi_bits = 2'b00;
      end
      assign live_b[gi] = {hi_bits, chan_status[gi*CH_BITS +: CH_BITS]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) snap_b[i] <= '0;
      end else if (snap_stb) begin
         for (int i = 0; i < NCH; i++) snap_b[i] <= live_b[i];
      end
   end

   assign rd_byte = snap_stb ? live_b[rd_idx] : snap_b[rd_idx];

   // R6: the link never commits beyond the two instruction bytes
   p_wr_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (wr_idx < IDX_W'(2)));

endmodule

// File: rtl/amp_ctl_i2c_slave.sv
module amp_ctl_i2c_slave
   import amp_ctl_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR      = 7'h6C,
   parameter int unsigned NCH           = 4,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          GLITCH_FILTER = 1'b0,
   localparam int unsigned IDX_W        = $clog2(NCH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe_o,
   input  logic [NCH*CH_BITS-1:0] chan_status_i,
   input  logic                   thermal_warn_i,
   input  logic                   cycle_done_i,
   input  logic                   offset_active_i,
   input  logic                   cursens_active_i,
   output logic                   diag_en_o,
   output logic                   offset_en_o,
   output logic                   front_gain_lo_o,
   output logic                   rear_gain_lo_o,
   output logic                   front_unmute_o,
   output logic                   rear_unmute_o,
   output logic                   clip_sel_o,
   output logic                   amp_run_o,
   output logic                   line_drv_o,
   output logic                   cur_det_en_o,
   output logic                   rearm_o
);

   logic scl_hi, sda_hi, scl_rise, scl_fall, start_ev, stop_ev;
   logic wr_stb, snap_stb;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [BYTE_W-2:0] wr_data;
   logic [BYTE_W-1:0] rd_byte;

   amp_ctl_i2c_sync #(.STAGES(SYNC_STAGES), .FILTER(GLITCH_FILTER)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_hi(scl_hi), .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   amp_ctl_i2c_link #(.DEV_ADDR(DEV_ADDR), .WR_BYTES(2), .RD_BYTES(NCH)) u_link (
      .clk(clk), .rst_n(rst_n), .scl_hi(scl_hi), .sda_hi(sda_hi),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
      .rd_byte(rd_byte), .sda_oe(sda_oe_o), .wr_stb(wr_stb), .wr_idx(wr_idx),
      .wr_data(wr_data), .snap_stb(snap_stb), .rd_idx(rd_idx), .done_stb(rearm_o)
   );

   amp_ctl_regs #(.NCH(NCH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
      .snap_stb(snap_stb), .rd_idx(rd_idx), .chan_status(chan_status_i),
      .thermal_warn(thermal_warn_i), .cycle_done(cycle_done_i),
      .offset_active(offset_active_i), .cursens_active(cursens_active_i),
      .rd_byte(rd_byte), .diag_en(diag_en_o), .offset_en(offset_en_o),
      .front_gain_lo(front_gain_lo_o), .rear_gain_lo(rear_gain_lo_o),
      .front_unmute(front_unmute_o), .rear_unmute(rear_unmute_o),
      .clip_sel(clip_sel_o), .amp_run(amp_run_o), .line_drv(line_drv_o),
      .cur_det_en(cur_det_en_o)
   );

   // R10: the rearm strobe lasts one clock
   p_rearm_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rearm_o |=> !rearm_o);

   // R10: rearm coincides with a released data line (master owns the ack slot)
   p_rearm_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rearm_o |-> !sda_oe_o);

endmodule

// File: tb/amp_ctl_i2c_slave_tb.sv
module amp_ctl_i2c_slave_tb_top;

   localparam int Q = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_line;
   logic [23:0] chan_st = '0;
   logic therm = 1'b0, cyc = 1'b0, offa = 1'b0, csa = 1'b0;
   logic diag_en, offset_en, fgl, rgl, fum, rum, clip, run, line, cur, rearm;

   int n_chk = 0;
   int n_err = 0;
   int rearm_cnt = 0;
   int glitches = 0;
   logic [6:0] exp_a = '0;
   logic [2:0] exp_b = '0;

   always #2.5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   amp_ctl_i2c_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .chan_status_i(chan_st), .thermal_warn_i(therm), .cycle_done_i(cyc),
      .offset_active_i(offa), .cursens_active_i(csa),
      .diag_en_o(diag_en), .offset_en_o(offset_en), .front_gain_lo_o(fgl),
      .rear_gain_lo_o(rgl), .front_unmute_o(fum), .rear_unmute_o(rum),
      .clip_sel_o(clip), .amp_run_o(run), .line_drv_o(line), .cur_det_en_o(cur),
      .rearm_o(rearm)
   );

   always @(posedge clk) if (rst_n && rearm) rearm_cnt++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b1; wait_q();
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; wait_q();
      scl_m = 1'b1; wait_q(); wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic bit_in(output logic b);
      logic s1, s2;
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1;
      repeat (3) @(posedge clk);
      #1 s1 = sda_line;
      wait_q();
      b = sda_line;
      repeat (Q - 4) @(posedge clk);
      #1 s2 = sda_line;
      if (s1 !== b || s2 !== b) glitches++;
      #1;
      scl_m = 1'b0; wait_q();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
      bit_in(a);
      acked = ~a;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] v);
      for (int i = 7; i >= 0; i--) bit_in(v[i]);
      bit_out(~give_ack);
   endtask

   function automatic logic [9:0] ctl_now();
      return {diag_en, offset_en, fgl, rgl, fum, rum, clip, run, line, cur};
   endfunction

   function automatic logic [9:0] ctl_exp();
      return {exp_a, exp_b};
   endfunction

   function automatic logic [7:0] exp_db(input int n, input logic [23:0] st,
                                         input logic [3:0] fl, input logic [1:0] echo);
      case (n)
         0: return {fl[3], fl[2], st[5:0]};
         1: return {fl[1], fl[0], st[11:6]};
         2: return {echo, st[17:12]};
         default: return {2'b00, st[23:18]};
      endcase
   endfunction

   task automatic do_write(input logic [7:0] a, input logic [7:0] b, input string tag);
      logic ack;
      i2c_start();
      send_byte(8'hD8, ack); chk({tag, " R2 write address ack"}, ack, 1);
      send_byte(a, ack);     chk({tag, " R6 first byte ack"}, ack, 1);
      send_byte(b, ack);     chk({tag, " R6 second byte ack"}, ack, 1);
      i2c_stop();
      exp_a = a[6:0];
      exp_b = b[4:2];
   endtask

   task automatic t_reset();
      repeat (4) @(posedge clk); #1;
      chk("R1 controls after reset", ctl_now(), 0);
      chk("R1 sda released after reset", sda_oe, 0);
      chk("R1 no rearm after reset", rearm_cnt, 0);
   endtask

   task automatic t_write_fields();
      do_write(8'h55, 8'h14, "pattern1");
      chk("R4 first byte fields 0x55", {diag_en, offset_en, fgl, rgl, fum, rum, clip}, 7'b1010101);
      chk("R5 second byte fields 0x14", {run, line, cur}, 3'b101);
      do_write(8'hAA, 8'hEB, "pattern2");
      chk("R4 first byte fields 0xAA bit7 ignored", {diag_en, offset_en, fgl, rgl, fum, rum, clip}, 7'b0101010);
      chk("R5 second byte fields 0xEB spare bits ignored", {run, line, cur}, 3'b010);
   endtask

   task automatic t_bad_addr();
      logic ack;
      i2c_start();
      send_byte(8'hA0, ack); chk("R2 foreign address not acked", ack, 0);
      send_byte(8'h7F, ack); chk("R2 bytes after foreign address not acked", ack, 0);
      send_byte(8'h1C, ack);
      i2c_stop();
      chk("R2 controls untouched by foreign transfer", ctl_now(), ctl_exp());
   endtask

   task automatic t_extra_byte();
      logic ack;
      i2c_start();
      send_byte(8'hD8, ack);
      send_byte(8'h40, ack);
      send_byte(8'h10, ack);
      send_byte(8'h7F, ack); chk("R6 third write byte not acked", ack, 0);
      i2c_stop();
      exp_a = 7'h40; exp_b = 3'b100;
      chk("R6 third byte changes nothing", ctl_now(), ctl_exp());
   endtask

   task automatic t_partial();
      logic ack;
      i2c_start();
      send_byte(8'hD8, ack);
      for (int i = 0; i < 4; i++) bit_out(1'b1);
      i2c_stop();
      chk("R3 truncated first byte ignored", ctl_now(), ctl_exp());
      i2c_start();
      send_byte(8'hD8, ack);
      send_byte(8'h3F, ack);
      for (int i = 0; i < 5; i++) bit_out(1'b1);
      i2c_start();
      i2c_stop();
      exp_a = 7'h3F;
      chk("R3 acked byte kept, cut second byte ignored", ctl_now(), ctl_exp());
   endtask

   task automatic t_read();
      logic ack;
      logic [7:0] v;
      int r0;
      chan_st = 24'b101010_010101_110011_001100;
      {therm, cyc, offa, csa} = 4'b1001;
      r0 = rearm_cnt;
      glitches = 0;
      i2c_start();
      send_byte(8'hD9, ack); chk("R2 read address ack", ack, 1);
      for (int n = 0; n < 4; n++) begin
         recv_byte(1'b1, v);
         chk($sformatf("R7 R8 read byte %0d", n), v,
             exp_db(n, chan_st, 4'b1001, {exp_b[2], exp_a[6]}));
      end
      i2c_stop();
      chk("R10 one rearm pulse per full read", rearm_cnt - r0, 1);
      chk("R12 sda steady during scl high", glitches, 0);
   endtask

   task automatic t_echo();
      logic ack;
      logic [7:0] v;
      do_write(8'h40, 8'h10, "echo");
      i2c_start();
      send_byte(8'hD9, ack);
      recv_byte(1'b1, v); recv_byte(1'b1, v); recv_byte(1'b1, v);
      chk("R8 byte 2 echoes run and diag enable", v[7:6], 2'b11);
      recv_byte(1'b1, v);
      chk("R8 byte 3 upper bits zero", v[7:6], 2'b00);
      i2c_stop();
   endtask

   task automatic t_snapshot();
      logic ack;
      logic [7:0] v;
      logic [23:0] st_a;
      st_a = 24'h5A_C3_96;
      chan_st = st_a;
      {therm, cyc, offa, csa} = 4'b0110;
      i2c_start();
      send_byte(8'hD9, ack);
      chan_st = ~st_a;
      {therm, cyc, offa, csa} = 4'b1001;
      for (int n = 0; n < 4; n++) begin
         recv_byte(1'b1, v);
         chk($sformatf("R9 frozen byte %0d", n), v,
             exp_db(n, st_a, 4'b0110, {exp_b[2], exp_a[6]}));
      end
      i2c_stop();
      i2c_start();
      send_byte(8'hD9, ack);
      for (int n = 0; n < 4; n++) begin
         recv_byte(1'b1, v);
         chk($sformatf("R9 next read byte %0d", n), v,
             exp_db(n, ~st_a, 4'b1001, {exp_b[2], exp_a[6]}));
      end
      i2c_stop();
   endtask

   task automatic t_nack();
      logic ack;
      logic [7:0] v;
      int r0;
      chan_st = '0;
      r0 = rearm_cnt;
      i2c_start();
      send_byte(8'hD9, ack);
      recv_byte(1'b1, v);
      recv_byte(1'b0, v);
      recv_byte(1'b1, v);
      chk("R11 released after master nack", v, 8'hFF);
      chk("R11 no drive after nack", sda_oe, 0);
      i2c_stop();
      chk("R10 no rearm for early-ended read", rearm_cnt - r0, 0);
   endtask

   initial begin
      repeat (10) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_write_fields();
      t_bad_addr();
      t_extra_byte();
      t_partial();
      t_read();
      t_echo();
      t_snapshot();
      t_nack();
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule